// File: doc/BRIEF.md
# Low-Side Peak Current Chopper Timer

This block holds the timing and decision logic that sits between the current comparators of an H-bridge low-side stage and its gate drivers. Each stage reports two digital flags: the load current is above the programmed limit, and the load current is above the overcurrent shutdown level. When the limit flag stays high for a full blanking window, the block forces that stage to freewheel. The low-side switch turns off and the high-side switch on the same half-bridge turns on for a fixed off-time. After the off-time the normal gate command returns.

If the shutdown flag stays high for longer than a short fault filter while the stage is still inside its blanking window, the event is a hard short to the supply rather than a limit event. The block emits a one-cycle short pulse that the device-level fault logic turns into a latched lockout. Every chop event sets a sticky per-stage limit flag and raises a charge-pump power request. A small register holds the 2-bit limit-level code and presents it one-hot to the analog threshold selector. The blanking time, off-time and filter time are parameters in clock cycles. The comparator flags can optionally pass through a synchronizer chain.

Top module: `clim_chopper_top`

## Requirements
- R1: After reset every stage passes `cmd_ls`/`cmd_hs` straight to `drv_ls`/`drv_hs`. `clim_flag`, `short_vs` and `chp_boost` are 0, and `lvl_sel` is 4'b0100, which is level code 2'b10.
- R2: If a stage's limit flag is sampled high on TB_CYC consecutive clock edges while the stage is enabled, the stage enters override right after the last of those edges. In override `drv_ls` is 0 and `drv_hs` is 1.
- R3: Override lasts exactly TA_CYC clock cycles and then releases. If the limit flag is still high, the blanking count starts again from zero, so the next override needs TB_CYC more high samples.
- R4: If the limit flag is sampled low before TB_CYC consecutive highs are reached, the blanking count returns to zero and the gate commands pass through unchanged.
- R5: Entering override sets that stage's bit of `clim_flag`. The bit stays set until `diag_clr` is sampled high. If a new override starts in the same cycle as a clear, the bit stays set.
- R6: While a stage is blanking (enabled, not in override, limit flag high), the shutdown flag may be sampled high on FLT_CYC consecutive edges. In that case `short_vs` for that stage is 1 for exactly one cycle. It does not pulse again while the shutdown flag stays high.
- R7: If the short is detected on the same edge on which the blanking window would expire, the short takes priority: no override starts and `clim_flag` is not set. No override starts while the shutdown flag remains high after a short.
- R8: `chp_boost` is 1 in every cycle in which at least one stage is in override, and 0 otherwise.
- R9: While `out_en` is 0 or `lockout` is 1, all counters are cleared and no override is active. An override in progress ends after the next clock edge.
- R10: A cycle with `lvl_wr` high loads `lvl_din`. `lvl_sel` is one-hot with bit index equal to the code, so code 2'b11 (bit 3) selects the highest limit and 2'b00 (bit 0) the lowest.
- R11: Stages are independent: limit, shutdown and override activity on one stage does not change the outputs of another stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_en | input | 1 | Bridge output enable state |
| lockout | input | 1 | Device in fault lockout |
| lim_hit | input | NSTG | Per-stage current above programmed limit |
| ocp_hit | input | NSTG | Per-stage current above shutdown level |
| cmd_ls | input | NSTG | Normal low-side gate command |
| cmd_hs | input | NSTG | Normal high-side gate command |
| diag_clr | input | 1 | Clears the sticky limit flags |
| lvl_wr | input | 1 | Load strobe for the limit-level code |
| lvl_din | input | 2 | Limit-level code to load |
| drv_ls | output | NSTG | Low-side gate drive after override |
| drv_hs | output | NSTG | High-side gate drive after override |
| clim_flag | output | NSTG | Sticky per-stage current-limit flag |
| short_vs | output | NSTG | One-cycle short-to-supply pulse per stage |
| chp_boost | output | 1 | Request for charge-pump high-power mode |
| lvl_sel | output | 4 | One-hot limit-level select |

## Verification
Two decisions can fall due on the same clock edge: expiry of the blanking window and the fault filter reaching its count. The bench raises the limit flag first. It then raises the shutdown flag exactly FLT_CYC edges before the TB_CYC-th limit sample, so both counters reach their thresholds together. That edge is judged by a short pulse with no override, no `chp_boost` and a clear `clim_flag`, and by the absence of any later override while the shutdown flag stays high. A second overlap, an override starting in the same cycle as a flag clear, is provoked by pulsing `diag_clr` on the trip edge and checking that the flag remains set.

// File: rtl/clim_pkg.sv
package clim_pkg;

   typedef logic [1:0] lvl_code_t;

   localparam lvl_code_t LVL_RST = 2'b10;

   function automatic logic [3:0] lvl_decode(lvl_code_t code);
      logic [3:0] r;
      r       = '0;
      r[code] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/clim_sync.sv
module clim_sync #(
   parameter int W      = 2,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("clim_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] sr [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) sr[k] <= '0;
         end else begin
            sr[0] <= d;
            for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/clim_blank.sv
module clim_blank #(
   parameter int TB_CYC  = 1000,
   parameter int FLT_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_ok,
   input  logic chop,
   input  logic lim,
   input  logic ocp,
   output logic trip,
   output logic short_p
);

   localparam int BW = $clog2(TB_CYC + 1);
   localparam int FW = $clog2(FLT_CYC + 1);
   localparam logic [BW-1:0] BLK_LAST = BW'(TB_CYC - 1);
   localparam logic [FW-1:0] FLT_LAST = FW'(FLT_CYC - 1);
   localparam logic [FW-1:0] FLT_SAT  = FW'(FLT_CYC);

   logic [BW-1:0] blk_q;
   logic [FW-1:0] flt_q;
   logic          short_q;
   logic          blanking;
   logic          short_now;
   logic          flt_sat;

   assign blanking  = en_ok & ~chop & lim;
   assign short_now = blanking & ocp & (flt_q == FLT_LAST);
   assign flt_sat   = (flt_q == FLT_SAT);
   // short detection outranks window expiry on the same edge (R7)
   assign trip      = blanking & (blk_q == BLK_LAST) & ~short_now & ~flt_sat;
   assign short_p   = short_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q   <= '0;
         flt_q   <= '0;
         short_q <= 1'b0;
      end else if (!blanking) begin
         blk_q   <= '0;
         flt_q   <= '0;
         short_q <= 1'b0;
      end else begin
         blk_q   <= (blk_q == BLK_LAST) ? blk_q : blk_q + 1'b1;
         if (!ocp)         flt_q <= '0;
         else if (!flt_sat) flt_q <= flt_q + 1'b1;
         short_q <= short_now;
      end
   end

   // R6: a short report is a single-cycle pulse
   p_short_single_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      short_p |=> !short_p);

   // R9: disabled stage keeps its blanking count at zero
   p_blank_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !en_ok |=> (blk_q == '0) && (flt_q == '0));

endmodule

// File: rtl/clim_offtime.sv
module clim_offtime #(
   parameter int TA_CYC = 1175
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_ok,
   input  logic trip,
   output logic chop
);

   localparam int AW = $clog2(TA_CYC + 1);
   localparam logic [AW-1:0] OFF_LAST = AW'(TA_CYC - 1);

   logic [AW-1:0] off_q;
   logic          chop_q;

   assign chop = chop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= '0;
         chop_q <= 1'b0;
      end else if (!en_ok) begin
         off_q  <= '0;
         chop_q <= 1'b0;
      end else if (chop_q) begin
         if (off_q == OFF_LAST) begin
            off_q  <= '0;
            chop_q <= 1'b0;
         end else begin
            off_q  <= off_q + 1'b1;
         end
      end else if (trip) begin
         off_q  <= '0;
         chop_q <= 1'b1;
      end
   end

   // R2: override starts only on a blanking trip
   p_chop_needs_trip_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chop) |-> $past(trip));

   // R9: override never survives a disabled cycle
   p_idle_when_off_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_ok) |-> !chop);

endmodule

// File: rtl/clim_lvl_reg.sv
module clim_lvl_reg
   import clim_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr,
   input  lvl_code_t din,
   output logic [3:0] sel
);

   lvl_code_t code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q <= LVL_RST;
      else if (wr) code_q <= din;
   end

   assign sel = lvl_decode(code_q);

   // R10: exactly one limit level is selected
   p_lvl_onehot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) == 1);

   // R10: level changes only on a write
   p_lvl_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr) |-> $stable(sel));

endmodule

// File: rtl/clim_chopper_top.sv
module clim_chopper_top
   import clim_pkg::*;
#(
   parameter int NSTG        = 2,
   parameter int TB_CYC      = 1000,
   parameter int TA_CYC      = 1175,
   parameter int FLT_CYC     = 100,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            out_en,
   input  logic            lockout,
   input  logic [NSTG-1:0] lim_hit,
   input  logic [NSTG-1:0] ocp_hit,
   input  logic [NSTG-1:0] cmd_ls,
   input  logic [NSTG-1:0] cmd_hs,
   input  logic            diag_clr,
   input  logic            lvl_wr,
   input  logic [1:0]      lvl_din,
   output logic [NSTG-1:0] drv_ls,
   output logic [NSTG-1:0] drv_hs,
   output logic [NSTG-1:0] clim_flag,
   output logic [NSTG-1:0] short_vs,
   output logic            chp_boost,
   output logic [3:0]      lvl_sel
);

   localparam int FW = 2 * NSTG;

   if (NSTG < 1) begin : g_bad_nstg
      $error("clim_chopper_top: NSTG must be at least 1");
   end
   if (TB_CYC < 2) begin : g_bad_tb
      $error("clim_chopper_top: TB_CYC must be at least 2");
   end
   if (TA_CYC < TB_CYC) begin : g_bad_ta
      $error("clim_chopper_top: TA_CYC must not be shorter than TB_CYC");
   end
   if (FLT_CYC < 1 || FLT_CYC >= TB_CYC) begin : g_bad_flt
      $error("clim_chopper_top: FLT_CYC must be in 1..TB_CYC-1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("clim_chopper_top: SYNC_STAGES must be in 0..3");
   end

   logic            en_ok;
   logic [FW-1:0]   flags_s;
   logic [NSTG-1:0] lim_s;
   logic [NSTG-1:0] ocp_s;
   logic [NSTG-1:0] chop;
   logic [NSTG-1:0] trip;
   logic [NSTG-1:0] clim_q;

   assign en_ok = out_en & ~lockout;

   clim_sync #(
      .W      (FW),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ocp_hit, lim_hit}),
      .q     (flags_s)
   );

   assign lim_s = flags_s[NSTG-1:0];
   assign ocp_s = flags_s[FW-1:NSTG];

   for (genvar i = 0; i < NSTG; i++) begin : g_stg

      clim_blank #(
         .TB_CYC  (TB_CYC),
         .FLT_CYC (FLT_CYC)
      ) u_blank (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_ok   (en_ok),
         .chop    (chop[i]),
         .lim     (lim_s[i]),
         .ocp     (ocp_s[i]),
         .trip    (trip[i]),
         .short_p (short_vs[i])
      );

      clim_offtime #(
         .TA_CYC (TA_CYC)
      ) u_off (
         .clk   (clk),
         .rst_n (rst_n),
         .en_ok (en_ok),
         .trip  (trip[i]),
         .chop  (chop[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        clim_q[i] <= 1'b0;
         else if (trip[i])  clim_q[i] <= 1'b1;
         else if (diag_clr) clim_q[i] <= 1'b0;
      end

      assign drv_ls[i] = chop[i] ? 1'b0 : cmd_ls[i];
      assign drv_hs[i] = chop[i] ? 1'b1 : cmd_hs[i];

      // R5: the sticky flag is set whenever an override begins
      p_clim_on_chop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(chop[i]) |-> clim_q[i]);

      // R7: a short report and a new override never share a cycle
      p_short_beats_chop_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         short_vs[i] |-> !chop[i]);
   end

   assign clim_flag = clim_q;
   assign chp_boost = |chop;

   clim_lvl_reg u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (lvl_wr),
      .din   (lvl_din),
      .sel   (lvl_sel)
   );

   // R8: boost request follows override activity
   p_boost_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (drv_hs & ~cmd_hs) != '0 |-> chp_boost);

endmodule

// File: tb/sim_clim_chopper_top.sv
module sim_clim_chopper_top;

   localparam int N   = 2;
   localparam int TB  = 8;
   localparam int TA  = 10;
   localparam int FLT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         out_en = 1'b0;
   logic         lockout = 1'b0;
   logic [N-1:0] lim_hit = '0;
   logic [N-1:0] ocp_hit = '0;
   logic [N-1:0] cmd_ls = 2'b11;
   logic [N-1:0] cmd_hs = 2'b00;
   logic         diag_clr = 1'b0;
   logic         lvl_wr = 1'b0;
   logic [1:0]   lvl_din = 2'b00;
   logic [N-1:0] drv_ls, drv_hs, clim_flag, short_vs;
   logic         chp_boost;
   logic [3:0]   lvl_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   clim_chopper_top #(
      .NSTG (N), .TB_CYC (TB), .TA_CYC (TA), .FLT_CYC (FLT), .SYNC_STAGES (0)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .out_en (out_en), .lockout (lockout),
      .lim_hit (lim_hit), .ocp_hit (ocp_hit), .cmd_ls (cmd_ls), .cmd_hs (cmd_hs),
      .diag_clr (diag_clr), .lvl_wr (lvl_wr), .lvl_din (lvl_din),
      .drv_ls (drv_ls), .drv_hs (drv_hs), .clim_flag (clim_flag),
      .short_vs (short_vs), .chp_boost (chp_boost), .lvl_sel (lvl_sel)
   );

   // {code, expected one-hot}
   localparam logic [5:0] LVL_TAB [4] = '{
      {2'b00, 4'b0001}, {2'b01, 4'b0010}, {2'b11, 4'b1000}, {2'b10, 4'b0100}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reset_stage;
      lim_hit = '0;
      ocp_hit = '0;
      out_en  = 1'b0;
      tick(1);
      out_en  = 1'b1;
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 drv_ls", drv_ls, 2'b11);
      chk("R1 drv_hs", drv_hs, 2'b00);
      chk("R1 clim_flag", clim_flag, 0);
      chk("R1 short_vs", short_vs, 0);
      chk("R1 chp_boost", chp_boost, 0);
      chk("R1 lvl_sel", lvl_sel, 4'b0100);

      // R10 table of level codes
      for (int k = 0; k < 4; k++) begin
         lvl_din = LVL_TAB[k][5:4];
         lvl_wr  = 1'b1;
         tick(1);
         lvl_wr  = 1'b0;
         lvl_din = ~LVL_TAB[k][5:4];
         tick(1);
         chk("R10 lvl_sel", lvl_sel, LVL_TAB[k][3:0]);
      end

      out_en = 1'b1;
      tick(1);

      // R2 trip after TB samples
      lim_hit[0] = 1'b1;
      tick(TB - 1);
      chk("R2 no override before TB", drv_ls[0], 1);
      tick(1);
      chk("R2 drv_ls off", drv_ls[0], 0);
      chk("R2 drv_hs on", drv_hs[0], 1);
      chk("R8 boost on", chp_boost, 1);
      chk("R5 clim set", clim_flag[0], 1);
      chk("R11 other stage untouched", {drv_ls[1], drv_hs[1], clim_flag[1]}, 3'b100);

      // R3 off-time length and restart
      tick(TA - 1);
      chk("R3 override still on", drv_hs[0], 1);
      tick(1);
      chk("R3 released", {drv_ls[0], drv_hs[0]}, 2'b10);
      chk("R8 boost off", chp_boost, 0);
      tick(TB - 1);
      chk("R3 restart from zero", drv_ls[0], 1);
      tick(1);
      chk("R3 second override", drv_ls[0], 0);

      // R9 disable ends override next edge
      out_en = 1'b0;
      tick(1);
      chk("R9 disable releases", {drv_ls[0], drv_hs[0]}, 2'b10);
      tick(TB + 2);
      chk("R9 no trip while disabled", drv_ls[0], 1);

      // R5 clear
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
      chk("R5 clim cleared", clim_flag[0], 0);

      // R4 drop before TB
      lim_hit[0] = 1'b0;
      out_en = 1'b1;
      tick(1);
      lim_hit[0] = 1'b1;
      tick(TB - 1);
      lim_hit[0] = 1'b0;
      tick(1);
      lim_hit[0] = 1'b1;
      tick(TB - 1);
      chk("R4 count restarted", drv_ls[0], 1);
      chk("R4 clim untouched", clim_flag[0], 0);
      tick(1);
      chk("R4 full window trips", drv_ls[0], 0);
      reset_stage();

      // R5 set wins over clear
      lim_hit[0] = 1'b1;
      tick(TB - 1);
      diag_clr = 1'b1;
      tick(1);
      diag_clr = 1'b0;
      chk("R5 set wins", clim_flag[0], 1);
      reset_stage();
      chk("R5 cleared again", clim_flag[0], 0);

      // R6 short pulse
      lim_hit[0] = 1'b1;
      ocp_hit[0] = 1'b1;
      tick(FLT - 1);
      chk("R6 no early short", short_vs[0], 0);
      tick(1);
      chk("R6 short pulse", short_vs[0], 1);
      tick(1);
      chk("R6 single pulse", short_vs[0], 0);
      tick(TB);
      chk("R7 blocked after short", drv_ls[0], 1);
      chk("R6 no repeat", short_vs[0], 0);
      reset_stage();

      // R7 coincidence of short and window expiry
      lim_hit[0] = 1'b1;
      tick(TB - FLT);
      ocp_hit[0] = 1'b1;
      tick(FLT - 1);
      chk("R7 pre-edge short", short_vs[0], 0);
      tick(1);
      chk("R7 short on expiry edge", short_vs[0], 1);
      chk("R7 no override", drv_ls[0], 1);
      chk("R7 no boost", chp_boost, 0);
      chk("R7 no clim", clim_flag[0], 0);
      reset_stage();

      // R9 lockout
      lim_hit[0] = 1'b1;
      tick(TB);
      chk("R9 override before lockout", drv_ls[0], 0);
      lockout = 1'b1;
      tick(1);
      chk("R9 lockout releases", {drv_ls[0], drv_hs[0]}, 2'b10);
      lockout = 1'b0;
      reset_stage();

      // R11 stage 1 alone
      lim_hit[1] = 1'b1;
      tick(TB);
      chk("R11 stage1 override", {drv_ls[1], drv_hs[1]}, 2'b01);
      chk("R11 stage0 passes", {drv_ls[0], drv_hs[0]}, 2'b10);
      chk("R11 clim per stage", clim_flag, 2'b10);
      chk("R8 boost from stage1", chp_boost, 1);
      reset_stage();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule